// File: doc/BRIEF.md
# Fixed-Page Hardware Stack Pointer

This block keeps the address of the next free stack slot for a small controller whose return stack lives in data RAM. Each stack entry takes four 4-bit words. The pointer is 10 bits wide, and its top four bits are tied to 1111, so the stack always sits in one 64-word page. Only the low six bits move, in steps of four, which gives room for sixteen entries. Push and pop strobes step the pointer down and up. A write of zero to a software control bit returns the pointer to its start value, and so does the system reset.

Alongside the pointer the block outputs the four word addresses of the current entry, so the surrounding logic can save or restore the program counter and flags without doing its own arithmetic. It also keeps a depth count. A push into a full stack or a pop from an empty one raises a one-cycle error pulse. The stack RAM and its contents are outside this block.

Top module: `fixed_page_sp`

## Requirements
- R1: After reset (rstN low), spAddr is 0x3FF, depth is 0, and ovfErr and udfErr are 0.
- R2: A push on its own (pushReq=1, popReq=0, no reload) lowers spAddr by 4 at the next clock edge and raises depth by 1, unless depth is already 16.
- R3: A pop on its own (popReq=1, pushReq=0, no reload) raises spAddr by 4 at the next clock edge and lowers depth by 1, unless depth is already 0.
- R4: Bits 9:6 of spAddr are always 1111. The low six bits wrap modulo 64, so sixteen pushes from 0x3FF bring spAddr back to 0x3FF.
- R5: entryAddr holds four 10-bit words. Bits [10k+9:10k] equal spAddr minus k for k = 0..3, with the subtraction wrapping inside the page.
- R6: If pushReq and popReq are both 1 in the same cycle, spAddr and depth do not change.
- R7: rspWrEn=1 with rspWrVal=0 sets spAddr to 0x3FF and depth to 0 at the next edge. This takes priority over any push or pop in that cycle.
- R8: rspWrEn=1 with rspWrVal=1 has no effect on spAddr or depth.
- R9: A push while depth is 16 makes ovfErr 1 for exactly the following cycle. The pointer still steps down by 4 (wrapping) and depth stays at 16.
- R10: A pop while depth is 0 makes udfErr 1 for exactly the following cycle. The pointer still steps up by 4 (0x3FF becomes 0x3C3) and depth stays at 0.
- R11: depth reports the number of pushed entries, from 0 to 16, and never goes above 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pushReq | input | 1 | Push strobe, one cycle per entry |
| popReq | input | 1 | Pop strobe, one cycle per entry |
| rspWrEn | input | 1 | Write strobe for the stack-reinit control bit |
| rspWrVal | input | 1 | Value written to the control bit (0 reinitialises) |
| spAddr | output | 10 | Address of the next free stack slot |
| entryAddr | output | 40 | Four word addresses of the current entry, word k at bits [10k+9:10k] |
| depth | output | 5 | Number of entries on the stack |
| ovfErr | output | 1 | One-cycle pulse after a push into a full stack |
| udfErr | output | 1 | One-cycle pulse after a pop from an empty stack |

## Verification
A wrong pointer register shows up on spAddr and on all four entryAddr words at the first negedge after the faulty edge, because no extra stage sits between the register and the ports. A depth count that drifts from the pointer stays hidden until the stack reaches one of its ends. The bench therefore fills the stack completely and drains it past empty, so that a drifted count shows as a missing or misplaced ovfErr or udfErr pulse. The bench also runs reload at the same time as a push, and push at the same time as pop, because a wrong priority between them changes the pointer within a single cycle.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef struct packed {
    logic reload;
    logic stepDn;
    logic stepUp;
  } spStrobe_t;
endpackage

// File: rtl/sp_ctrl.sv
module sp_ctrl
  import sp_pkg::*;
#(
  parameter int LEVELS  = 16,
  parameter int DEPTH_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pushReq,
  input  logic               popReq,
  input  logic               rspWrEn,
  input  logic               rspWrVal,
  output spStrobe_t          strobe,
  output logic [DEPTH_W-1:0] depth,
  output logic               ovfErr,
  output logic               udfErr
);
  localparam logic [DEPTH_W-1:0] FULL = DEPTH_W'(LEVELS);

  logic reloadReq, atFull, atEmpty;

  always_comb begin
    reloadReq     = rspWrEn & ~rspWrVal;
    strobe.reload = reloadReq;
    strobe.stepDn = ~reloadReq & pushReq & ~popReq;
    strobe.stepUp = ~reloadReq & popReq & ~pushReq;
    atFull        = (depth == FULL);
    atEmpty       = (depth == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depth  <= '0;
      ovfErr <= 1'b0;
      udfErr <= 1'b0;
    end else begin
      ovfErr <= strobe.stepDn & atFull;
      udfErr <= strobe.stepUp & atEmpty;
      if (strobe.reload)
        depth <= '0;
      else if (strobe.stepDn && !atFull)
        depth <= depth + 1'b1;
      else if (strobe.stepUp && !atEmpty)
        depth <= depth - 1'b1;
    end
  end

  // R11
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    depth <= FULL);

  // R9
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfErr |-> ($past(strobe.stepDn) && $past(depth) == FULL && depth == FULL));

  // R10
  udf_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    udfErr |-> ($past(strobe.stepUp) && $past(depth) == '0 && depth == '0));

  // R6
  both_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && popReq && !reloadReq) |=> $stable(depth));

  // R7
  reload_depth_chk: assert property (@(posedge clk) disable iff (!rstN)
    reloadReq |=> (depth == '0));

  // R2
  push_depth_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepDn && !atFull) |=> (depth == $past(depth) + 1'b1));

  always_comb begin
    // R6
    strobe_excl_chk: assert ($onehot0({strobe.stepDn, strobe.stepUp}));
  end
endmodule

// File: rtl/sp_datapath.sv
module sp_datapath
  import sp_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int FIXED_W   = 4,
  parameter int WORD_STEP = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  spStrobe_t                     strobe,
  output logic [ADDR_W-1:0]             spAddr,
  output logic [WORD_STEP*ADDR_W-1:0]   entryAddr
);
  localparam int LOW_W = ADDR_W - FIXED_W;
  localparam logic [FIXED_W-1:0] PAGE = '1;
  localparam logic [LOW_W-1:0]   STEP = LOW_W'(WORD_STEP);
  localparam logic [LOW_W-1:0]   TOP  = '1;

  logic [LOW_W-1:0] ptrLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      ptrLow <= TOP;
    else if (strobe.reload)
      ptrLow <= TOP;
    else if (strobe.stepDn)
      ptrLow <= ptrLow - STEP;
    else if (strobe.stepUp)
      ptrLow <= ptrLow + STEP;
  end

  assign spAddr = {PAGE, ptrLow};

  for (genvar k = 0; k < WORD_STEP; k++) begin : gWord
    assign entryAddr[k*ADDR_W +: ADDR_W] = {PAGE, ptrLow - LOW_W'(k)};
  end

  // R2
  push_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepDn |=> (ptrLow == $past(ptrLow) - STEP));

  // R3
  pop_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepUp |=> (ptrLow == $past(ptrLow) + STEP));

  // R7
  reload_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> (ptrLow == TOP));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.reload && !strobe.stepDn && !strobe.stepUp) |=> $stable(ptrLow));
endmodule

// File: rtl/fixed_page_sp.sv
module fixed_page_sp
  import sp_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int FIXED_W   = 4,
  parameter int WORD_STEP = 4,
  localparam int LEVELS   = (1 << (ADDR_W - FIXED_W)) / WORD_STEP,
  localparam int DEPTH_W  = $clog2(LEVELS + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        pushReq,
  input  logic                        popReq,
  input  logic                        rspWrEn,
  input  logic                        rspWrVal,
  output logic [ADDR_W-1:0]           spAddr,
  output logic [WORD_STEP*ADDR_W-1:0] entryAddr,
  output logic [DEPTH_W-1:0]          depth,
  output logic                        ovfErr,
  output logic                        udfErr
);
  spStrobe_t strobe;

  sp_ctrl #(.LEVELS(LEVELS), .DEPTH_W(DEPTH_W)) uCtrl (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq),
    .rspWrEn(rspWrEn), .rspWrVal(rspWrVal), .strobe(strobe),
    .depth(depth), .ovfErr(ovfErr), .udfErr(udfErr)
  );

  sp_datapath #(.ADDR_W(ADDR_W), .FIXED_W(FIXED_W), .WORD_STEP(WORD_STEP)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .spAddr(spAddr), .entryAddr(entryAddr)
  );
endmodule

// File: tb/fixed_page_sp_test.sv
module fixed_page_sp_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushReq = 1'b0, popReq = 1'b0, rspWrEn = 1'b0, rspWrVal = 1'b0;
  logic [9:0]  spAddr;
  logic [39:0] entryAddr;
  logic [4:0]  depth;
  logic        ovfErr, udfErr;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  fixed_page_sp uut (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq),
    .rspWrEn(rspWrEn), .rspWrVal(rspWrVal), .spAddr(spAddr),
    .entryAddr(entryAddr), .depth(depth), .ovfErr(ovfErr), .udfErr(udfErr)
  );

  // vector: push pop wrEn wrVal | expSp[10] | expDepth[5] | ovf | udf
  localparam logic [20:0] VEC [10] = '{
    {4'b1000, 10'h3FB, 5'd1, 1'b0, 1'b0},  // R2
    {4'b1000, 10'h3F7, 5'd2, 1'b0, 1'b0},  // R2
    {4'b0100, 10'h3FB, 5'd1, 1'b0, 1'b0},  // R3
    {4'b1100, 10'h3FB, 5'd1, 1'b0, 1'b0},  // R6
    {4'b0011, 10'h3FB, 5'd1, 1'b0, 1'b0},  // R8
    {4'b1000, 10'h3F7, 5'd2, 1'b0, 1'b0},  // R2
    {4'b1010, 10'h3FF, 5'd0, 1'b0, 1'b0},  // R7 priority over push
    {4'b0100, 10'h3C3, 5'd0, 1'b0, 1'b1},  // R10
    {4'b0000, 10'h3C3, 5'd0, 1'b0, 1'b0},  // R10 pulse ends
    {4'b0010, 10'h3FF, 5'd0, 1'b0, 1'b0}   // R7
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag, input logic [9:0] eSp, input logic [4:0] eD,
                          input logic eO, input logic eU);
    check({tag, " spAddr"}, 32'(spAddr), 32'(eSp));
    check({tag, " depth R11"}, 32'(depth), 32'(eD));
    check({tag, " ovfErr R9"}, 32'(ovfErr), 32'(eO));
    check({tag, " udfErr R10"}, 32'(udfErr), 32'(eU));
    check({tag, " page R4"}, 32'(spAddr[9:6]), 32'hF);
    for (int k = 0; k < 4; k++) begin
      logic [5:0] lo;
      lo = eSp[5:0] - 6'(k);
      check({tag, " entry word R5"}, 32'(entryAddr[k*10 +: 10]), 32'({4'hF, lo}));
    end
  endtask

  // called at a negedge; applies inputs for one edge and returns at the next negedge
  task automatic apply(input logic pu, input logic po, input logic we, input logic wv);
    pushReq = pu; popReq = po; rspWrEn = we; rspWrVal = wv;
    @(negedge clk);
    pushReq = 0; popReq = 0; rspWrEn = 0; rspWrVal = 0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkAll("R1 reset", 10'h3FF, 5'd0, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 idle", 10'h3FF, 5'd0, 1'b0, 1'b0);

    for (int i = 0; i < 10; i++) begin
      apply(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17]);
      checkAll($sformatf("vec%0d", i), VEC[i][16:7], VEC[i][6:2], VEC[i][1], VEC[i][0]);
    end

    // R4 fill all sixteen levels and wrap; R9 overflow on the 17th push
    for (int n = 1; n <= 16; n++) begin
      logic [5:0] lo;
      lo = 6'h3F - 6'(4 * n);
      apply(1, 0, 0, 0);
      checkAll($sformatf("R2 fill %0d", n), {4'hF, lo}, 5'(n), 1'b0, 1'b0);
    end
    check("R4 wrap to top", 32'(spAddr), 32'h3FF);
    apply(1, 0, 0, 0);
    checkAll("R9 overflow", 10'h3FB, 5'd16, 1'b1, 1'b0);
    apply(0, 0, 0, 0);
    checkAll("R9 pulse one cycle", 10'h3FB, 5'd16, 1'b0, 1'b0);
    apply(0, 1, 0, 0);
    checkAll("R3 pop after overflow", 10'h3FF, 5'd15, 1'b0, 1'b0);
    apply(1, 1, 0, 0);
    checkAll("R6 both at depth 15", 10'h3FF, 5'd15, 1'b0, 1'b0);
    apply(0, 1, 1, 1);
    checkAll("R8 write one with pop", 10'h3C3, 5'd14, 1'b0, 1'b0);
    apply(0, 1, 1, 0);
    checkAll("R7 reload beats pop", 10'h3FF, 5'd0, 1'b0, 1'b0);

    // R1 reset in mid-run
    apply(1, 0, 0, 0);
    rstN = 1'b0;
    @(negedge clk);
    checkAll("R1 mid-run reset", 10'h3FF, 5'd0, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule